// File: doc/BRIEF.md
# SPI Clock Prescaler

This block derives the serial clock timing of an SPI controller from the core clock. It reads the prescale field of a configuration register and turns it into an integer divisor D. It then produces one-cycle strobes that tell the shift engine when to toggle SCK, which edge is the leading one and which is the trailing one. The encoding of the prescale field is fixed at build time by a parameter.

The compact encoding gives only even divisors, in the range 4 to 30. The wide encoding splits the field into a 4-bit mantissa and a 3-bit exponent, with the exponent bits placed at non-adjacent positions. It reaches divisors up to 1920, and also odd divisors when the exponent is zero. A second parameter sets the smallest divisor the clock path accepts. Any setting that decodes below this floor runs at the floor.

The shift engine holds `run_i` high while a transfer is in progress. While `run_i` is low the strobes stay quiet and SCK rests in its idle phase. When the field changes, the phase counter is reloaded, so a new rate never runs a truncated or overlong half-period.

Top module: `spi_clk_prescaler`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, all three strobe outputs are low.
- R2: While `run_i` is sampled low, no strobe is produced and the next phase is the idle (rest) phase. With the field stable, the first leading strobe appears after the ceil(D/2)-th clock edge at which `run_i` is sampled high.
- R3: In the wide format (FMT = PSC_EXTENDED), the mantissa M is field bits 3:0. The exponent E has its bit 0 in field bit 4 and its bits 2:1 in field bits 7:6. The raw divisor is M·2^E. Field bit 5 has no effect on timing.
- R4: In the compact format (FMT = PSC_LEGACY), a field value of 0x10+n in bits 4:0 gives a raw divisor of 2n. A value with bit 4 clear gives a raw divisor of 0. Field bits 7:5 have no effect on timing.
- R5: A raw divisor below MIN_DIV, including a mantissa of 0 and compact values below 0x12, is replaced by MIN_DIV.
- R6: After a leading strobe, the next trailing strobe follows floor(D/2) cycles later. After a trailing strobe, the next leading strobe follows ceil(D/2) cycles later.
- R7: Every strobe is one cycle wide. `sck_toggle_o` is high exactly when `lead_edge_o` or `trail_edge_o` is high, never both. Lead and trail strobes alternate, and each run begins with a lead.
- R8: A change in the effective (non-ignored) field bits, and the first cycle after reset, reload the counter at that clock edge. The reload uses the length of the current phase under the new divisor, produces no strobe and keeps the phase.
- R9: The largest wide setting (field 0xDF) gives D = 1920, with half-periods of 960 cycles.
- R10: A wide setting with exponent 0 and mantissa of at least MIN_DIV gives the mantissa itself as divisor, odd values included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Shift engine busy; low forces the idle phase |
| prescale_i | input | 8 | Prescale field of the configuration register |
| sck_toggle_o | output | 1 | One-cycle pulse: toggle SCK now |
| lead_edge_o | output | 1 | One-cycle pulse: this toggle is the leading edge |
| trail_edge_o | output | 1 | One-cycle pulse: this toggle is the trailing edge |

## Verification
On every cycle, the assertions check the following: the strobes stay quiet during idle, lead and trail are exclusive and alternate, the decoded divisor stays within the floor and 1920, the compact format yields only even divisors above the floor, and the phase counter never exceeds the current rest length. Exact half-period lengths, the placement of the split exponent bits, the clamping values, the ignored field bits and the reload on a mid-transfer change can only be shown by the bench. It runs a cycle-accurate reference model for three builds (wide with floor 4, compact, wide with floor 15) and compares it against each build on every clock.

// File: rtl/spi_prescale_pkg.sv
package spi_prescale_pkg;

    localparam int FIELD_W = 8;
    localparam int DIV_W   = 11;
    localparam int MAX_DIV = 15 << 7;

    typedef enum logic {
        PSC_LEGACY   = 1'b0,
        PSC_EXTENDED = 1'b1
    } psc_fmt_e;

    typedef logic [FIELD_W-1:0] psc_field_t;
    typedef logic [DIV_W-1:0]   psc_div_t;

    typedef struct packed {
        logic [3:0] mant;
        logic [2:0] expo;
    } psc_ext_t;

    typedef struct packed {
        psc_div_t act;   // cycles after a leading edge
        psc_div_t rest;  // cycles after a trailing edge / idle
    } psc_half_t;

    typedef struct packed {
        logic tgl;
        logic lead;
        logic trail;
    } psc_edge_t;

    function automatic psc_field_t field_mask(psc_fmt_e fmt);
        return (fmt == PSC_EXTENDED) ? psc_field_t'(8'hDF) : psc_field_t'(8'h1F);
    endfunction

    function automatic psc_ext_t ext_unpack(psc_field_t f);
        psc_ext_t r;
        r.mant = f[3:0];
        r.expo = {f[7:6], f[4]};
        return r;
    endfunction

    function automatic psc_half_t split_half(psc_div_t d);
        psc_half_t h;
        h.act  = d >> 1;
        h.rest = (d >> 1) + psc_div_t'(d[0]);
        return h;
    endfunction

endpackage

// File: rtl/psc_decode.sv
module psc_decode
    import spi_prescale_pkg::*;
#(
    parameter psc_fmt_e FMT     = PSC_EXTENDED,
    parameter int       MIN_DIV = 4
) (
    input  psc_field_t field_i,
    output psc_div_t   div_o
);
    localparam psc_div_t MIN_D = psc_div_t'(MIN_DIV);

    psc_div_t raw;

    generate
        if (FMT == PSC_EXTENDED) begin : g_ext
            psc_ext_t ef;
            logic     unused_bit5;
            assign ef          = ext_unpack(field_i);
            assign unused_bit5 = field_i[5];
            assign raw         = psc_div_t'(ef.mant) << ef.expo;
        end else begin : g_leg
            logic [2:0] unused_hi;
            assign unused_hi = field_i[7:5];
            assign raw = field_i[4] ? psc_div_t'({field_i[3:0], 1'b0}) : '0;
        end
    endgenerate

    assign div_o = (raw < MIN_D) ? MIN_D : raw;

endmodule

// File: rtl/psc_field_track.sv
module psc_field_track
    import spi_prescale_pkg::*;
#(
    parameter psc_fmt_e FMT = PSC_EXTENDED
) (
    input  logic       clk,
    input  logic       rst,
    input  psc_field_t field_i,
    output logic       reload_o
);
    localparam psc_field_t MASK = field_mask(FMT);

    psc_field_t eff;
    psc_field_t prev_q;
    logic       prime_q;

    assign eff      = field_i & MASK;
    assign reload_o = prime_q | (eff != prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            prime_q <= 1'b1;
        end else begin
            prev_q  <= eff;
            prime_q <= 1'b0;
        end
    end

    // R8: the reload marker is absent once the field has been stable for a cycle
    p_reload_settles_r8: assert property (@(posedge clk) disable iff (rst)
        ($stable(field_i) && !$past(rst)) |-> !reload_o);

endmodule

// File: rtl/psc_phase_ctr.sv
module psc_phase_ctr
    import spi_prescale_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run_i,
    input  logic      reload_i,
    input  psc_half_t half_i,
    output psc_edge_t edge_o
);
    psc_div_t cnt_q;
    logic     act_q;   // 1 while in the phase that follows a leading edge

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            act_q  <= 1'b0;
            edge_o <= '0;
        end else begin
            edge_o <= '0;
            if (!run_i) begin
                act_q <= 1'b0;
                cnt_q <= half_i.rest - 1'b1;
            end else if (reload_i) begin
                cnt_q <= (act_q ? half_i.act : half_i.rest) - 1'b1;
            end else if (cnt_q == '0) begin
                act_q        <= !act_q;
                edge_o.tgl   <= 1'b1;
                edge_o.lead  <= !act_q;
                edge_o.trail <= act_q;
                cnt_q        <= (act_q ? half_i.rest : half_i.act) - 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Checker state: a lead has been seen without its trail yet
    logic open_q;
    always_ff @(posedge clk) begin
        if (rst || !run_i)   open_q <= 1'b0;
        else if (edge_o.lead)  open_q <= 1'b1;
        else if (edge_o.trail) open_q <= 1'b0;
    end

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !edge_o.tgl);

    p_edge_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(edge_o.lead && edge_o.trail));

    p_lead_first_r7: assert property (@(posedge clk) disable iff (rst)
        edge_o.lead |-> !open_q);

    p_trail_after_lead_r7: assert property (@(posedge clk) disable iff (rst)
        edge_o.trail |-> open_q);

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        !reload_i |-> (cnt_q < half_i.rest));

endmodule

// File: rtl/spi_clk_prescaler.sv
module spi_clk_prescaler
    import spi_prescale_pkg::*;
#(
    parameter psc_fmt_e FMT     = PSC_EXTENDED,
    parameter int       MIN_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run_i,
    input  logic [7:0] prescale_i,
    output logic       sck_toggle_o,
    output logic       lead_edge_o,
    output logic       trail_edge_o
);
    localparam psc_div_t MIN_D = psc_div_t'(MIN_DIV);
    localparam psc_div_t MAX_D = psc_div_t'(MAX_DIV);

    psc_field_t field;
    psc_div_t   div;
    psc_half_t  half;
    logic       reload;
    psc_edge_t  edges;

    assign field = psc_field_t'(prescale_i);
    assign half  = split_half(div);

    psc_decode #(.FMT(FMT), .MIN_DIV(MIN_DIV)) u_decode (
        .field_i (field),
        .div_o   (div)
    );

    psc_field_track #(.FMT(FMT)) u_track (
        .clk      (clk),
        .rst      (rst),
        .field_i  (field),
        .reload_o (reload)
    );

    psc_phase_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .run_i    (run_i),
        .reload_i (reload),
        .half_i   (half),
        .edge_o   (edges)
    );

    assign sck_toggle_o = edges.tgl;
    assign lead_edge_o  = edges.lead;
    assign trail_edge_o = edges.trail;

    p_div_range_r5: assert property (@(posedge clk) disable iff (rst)
        (div >= MIN_D) && (div <= MAX_D));

    generate
        if (FMT == PSC_LEGACY) begin : g_leg_chk
            p_legacy_even_r4: assert property (@(posedge clk) disable iff (rst)
                (div != MIN_D) |-> !div[0]);
        end
    endgenerate

endmodule

// File: tb/sim_spi_clk_prescaler.sv
module sim_spi_clk_prescaler;
    import spi_prescale_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NI = 3;
    localparam int WATCHDOG = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic [7:0] fld = 8'h00;
    logic [NI-1:0] a_t, a_l, a_r;

    int    vectors = 0;
    int    fails   = 0;
    int    cycles  = 0;
    bit    done    = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_clk_prescaler #(.FMT(PSC_EXTENDED), .MIN_DIV(4)) u0 (
        .clk(clk), .rst(rst), .run_i(run), .prescale_i(fld),
        .sck_toggle_o(a_t[0]), .lead_edge_o(a_l[0]), .trail_edge_o(a_r[0]));

    spi_clk_prescaler #(.FMT(PSC_LEGACY), .MIN_DIV(4)) u1 (
        .clk(clk), .rst(rst), .run_i(run), .prescale_i(fld),
        .sck_toggle_o(a_t[1]), .lead_edge_o(a_l[1]), .trail_edge_o(a_r[1]));

    spi_clk_prescaler #(.FMT(PSC_EXTENDED), .MIN_DIV(15)) u2 (
        .clk(clk), .rst(rst), .run_i(run), .prescale_i(fld),
        .sck_toggle_o(a_t[2]), .lead_edge_o(a_l[2]), .trail_edge_o(a_r[2]));

    // Divisor per requirement R3, R4, R5 for each build
    function automatic int model_div(int i, int f);
        int raw, mn, v, spr, sppr;
        if (i == 1) begin
            v   = f & 31;
            raw = (v >= 16) ? 2 * (v - 16) : 0;
            mn  = 4;
        end else begin
            spr  = f & 15;
            sppr = ((f >> 4) & 1) | (((f >> 6) & 3) << 1);
            raw  = spr * (1 << sppr);
            mn   = (i == 2) ? 15 : 4;
        end
        return (raw < mn) ? mn : raw;
    endfunction

    function automatic int model_mask(int i);
        return (i == 1) ? 'h1F : 'hDF;
    endfunction

    // Behavioural reference: elapsed-cycle counters per build
    int m_el   [NI];
    bit m_hi   [NI];
    int m_prev [NI];
    bit m_prime;
    bit e_t [NI];
    bit e_l [NI];
    bit e_r [NI];

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            for (int i = 0; i < NI; i++) begin
                m_el[i] = 0; m_hi[i] = 0; m_prev[i] = 0;
                e_t[i] = 0; e_l[i] = 0; e_r[i] = 0;
            end
            m_prime = 1;
        end else begin
            for (int i = 0; i < NI; i++) begin
                int d, len, mf;
                bit chg;
                d   = model_div(i, int'(fld));
                mf  = int'(fld) & model_mask(i);
                chg = m_prime || (mf != m_prev[i]);
                e_t[i] = 0; e_l[i] = 0; e_r[i] = 0;
                if (!run) begin
                    m_hi[i] = 0;
                    m_el[i] = 0;
                end else if (chg) begin
                    m_el[i] = 0;
                end else begin
                    len = m_hi[i] ? (d / 2) : ((d + 1) / 2);
                    if (m_el[i] >= len - 1) begin
                        e_t[i] = 1;
                        e_l[i] = !m_hi[i];
                        e_r[i] = m_hi[i];
                        m_hi[i] = !m_hi[i];
                        m_el[i] = 0;
                    end else begin
                        m_el[i]++;
                    end
                end
                m_prev[i] = mf;
            end
            m_prime = 0;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            for (int i = 0; i < NI; i++) begin
                vectors++;
                if ({a_t[i], a_l[i], a_r[i]} !== {e_t[i], e_l[i], e_r[i]}) begin
                    fails++;
                    $display("FAIL %s u%0d cycle %0d: got tgl/lead/trail=%b%b%b expected %b%b%b",
                             cur_req, i, cycles, a_t[i], a_l[i], a_r[i],
                             e_t[i], e_l[i], e_r[i]);
                end
            end
        end
    end

    task automatic apply(input logic [7:0] f, input logic r, input int n, input string req);
        @(posedge clk);
        #2;
        cur_req = req;
        fld = f;
        run = r;
        repeat (n) @(posedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        // R1: reset state, then first cycle after release
        cur_req = "R1";
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        repeat (3) @(posedge clk);

        // R2: idle with a nonzero field, then start
        apply(8'h1A, 1'b0, 10, "R2");
        apply(8'h1A, 1'b1, 90, "R2,R6,R7");
        apply(8'h1A, 1'b0, 5,  "R2");
        apply(8'h1A, 1'b1, 7,  "R2");
        apply(8'h1A, 1'b0, 3,  "R2");

        // R10: odd direct divisors (wide builds); compact clamps
        apply(8'h05, 1'b1, 60,  "R10,R6");
        apply(8'h07, 1'b0, 2,   "R10");
        apply(8'h07, 1'b1, 60,  "R10,R6");
        apply(8'h0F, 1'b1, 80,  "R10,R6");

        // R3: split exponent bits
        apply(8'h4B, 1'b1, 200, "R3");
        apply(8'h13, 1'b1, 60,  "R3");
        apply(8'h83, 1'b1, 120, "R3");

        // R4: compact mapping across the range
        apply(8'h12, 1'b1, 40,  "R4");
        apply(8'h1F, 1'b1, 130, "R4");
        apply(8'hF5, 1'b1, 60,  "R4");

        // R5: clamping
        apply(8'h00, 1'b1, 50, "R5");
        apply(8'h10, 1'b1, 40, "R5");
        apply(8'h11, 1'b1, 40, "R5");
        apply(8'h02, 1'b1, 40, "R5");

        // R3, R4: ignored bits must not disturb the running clock
        apply(8'h0C, 1'b1, 17, "R3,R4");
        apply(8'h2C, 1'b1, 30, "R3,R4");
        apply(8'hEC, 1'b1, 30, "R4");

        // R8: effective changes mid-phase, both directions
        apply(8'h1A, 1'b1, 13, "R8");
        apply(8'h0C, 1'b1, 5,  "R8");
        apply(8'h1E, 1'b1, 9,  "R8");
        apply(8'h05, 1'b1, 1,  "R8");
        apply(8'h06, 1'b1, 40, "R8");

        // R9: largest wide divisor
        apply(8'hDF, 1'b0, 3,    "R9");
        apply(8'hDF, 1'b1, 4000, "R9");
        apply(8'hDF, 1'b0, 5,    "R9");

        // R1: reset asserted mid-run
        apply(8'h1A, 1'b1, 20, "R1");
        @(posedge clk); #2 rst = 1'b1; cur_req = "R1";
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        repeat (40) @(posedge clk);

        finish_run();
    end

    initial begin
        wait (cycles > WATCHDOG);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            finish_run();
        end
    end

endmodule